// File: doc/BRIEF.md
# Banded Affine-Gap Alignment Scorer

This block scores one short read against one reference segment with the local-alignment recurrences for affine gaps. It walks the cell grid one cell per clock, row by row, with rows indexed by read position and columns by reference position. It keeps only the previous row of the match, insertion and deletion values. No score matrix is stored and no traceback is done. Instead, a signed drift counter watches how each filled cell was reached. When the counter lands on a configured limit, the run stops early and reports no match. When every cell is processed without that happening, the run reports a match. In either case the block returns the largest filled value it met.

Before a run, the read and the reference are written base by base into two small local buffers, using 2-bit codes. The run is started with a one-cycle request that carries both lengths, the two gap penalties, the match bonus, the mismatch penalty and the drift limit. A one-cycle completion pulse follows, and the verdict and score stay on the outputs until the next run.

Top module: `sw_band_scorer`

## Requirements
- R1: A base written with `rd_wr_en` or `rf_wr_en` lands at 0-based position `*_wr_addr` of the read or reference buffer. Bases are 2-bit codes, and only equality of codes matters. The substitution score of cell (i,j) is +`match_bonus` when read base i-1 equals reference base j-1, and −`mismatch_pen` otherwise.
- R2: For each cell, M = max(0, max(Mdiag, Idiag, Ddiag) + substitution). I = max(Mup − open, Iup − ext). D = max(Mleft − open, Dleft − ext). The filled value is F = max(M, I, D). Here open is `gap_open`, ext is `gap_ext`, and arithmetic is signed with 21-bit cell values.
- R3: Row 0 cells at column j (j ≥ 1) hold −open − (j−1)·ext in all three of M, I and D. Column 0 cells hold M = 0 and large negative I and D.
- R4: A drift counter starts each run at 0. After each cell it moves −1 when F equals I. Otherwise it moves +1 when F equals D. Otherwise it is unchanged. I wins a tie with D.
- R5: When the drift counter, after a cell's update, equals the signed `band_limit`, the run stops at that cell and `matched` is 0. This holds even if the cell is the last one.
- R6: When all `rd_len`·`rf_len` cells are processed without a stop, `matched` is 1. `best_score` is the largest F over all processed cells, starting from 0, so it is never negative.
- R7: Cells are processed in row-major order, one per cycle, with `busy` high throughout. `done` is a one-cycle pulse, high in the cycle after the last processed cell, so it comes cells+1 cycles after the start edge. `busy` and `done` are never high together.
- R8: A start with `rd_len` = 0 or `rf_len` = 0 processes no cell. `done` follows after one cycle with `matched` = 1 and `best_score` = 0.
- R9: `start` is ignored while `busy` or `done` is high. `matched` and `best_score` hold their values until the next accepted start.
- R10: After reset, `busy`, `done`, `matched` and `best_score` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_wr_en | input | 1 | Write one read base |
| rd_wr_addr | input | 9 | Read buffer position (0-based) |
| rd_wr_base | input | 2 | Read base code |
| rf_wr_en | input | 1 | Write one reference base |
| rf_wr_addr | input | 9 | Reference buffer position (0-based) |
| rf_wr_base | input | 2 | Reference base code |
| rd_len | input | 9 | Read length for the run (0..400) |
| rf_len | input | 9 | Reference length for the run (0..400) |
| gap_open | input | 8 | Gap-open penalty |
| gap_ext | input | 8 | Gap-extend penalty |
| match_bonus | input | 8 | Score for equal bases |
| mismatch_pen | input | 8 | Penalty for unequal bases |
| band_limit | input | 20 | Signed drift limit that ends a run early |
| start | input | 1 | Start request, sampled only when idle |
| busy | output | 1 | Cells are being processed |
| done | output | 1 | One-cycle completion pulse |
| matched | output | 1 | 1 = run completed, 0 = stopped on the drift limit |
| best_score | output | 21 | Largest filled value of the run |

## Verification
The bound assertions check, on every cycle, the protocol around the run. They cover the single-cycle `done` pulse, the exclusion of `busy` and `done`, acceptance of a start and the one-cycle finish of an empty run. They also check that the drift counter moves by at most one per cell, that the running score never falls or goes negative, and that results hold while idle. Whether the recurrences, boundary values and tie order give the right verdict and score can only be shown by the bench. It replays each scenario through an independent model of the grid and compares the verdict, the score and the exact completion latency. Hand-worked cases cover a deletion-driven stop, an insertion-driven stop and a boundary-dependent score.

// File: rtl/sw_band_pkg.sv
package sw_band_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sw_base_store.sv
module sw_base_store #(
  parameter int MAX_LEN = 400,
  parameter int AW      = 9
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [1:0]    wr_base,
  input  logic [AW-1:0] rd_idx,
  output logic [1:0]    rd_base
);
  logic [1:0] base_mem [MAX_LEN];

  always_ff @(posedge clk) begin
    if (wr_en) base_mem[wr_idx] <= wr_base;
  end

  assign rd_base = base_mem[rd_idx];
endmodule

// File: rtl/sw_row_store.sv
module sw_row_store #(
  parameter int MAX_LEN = 400,
  parameter int AW      = 9,
  parameter int SW      = 21
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [AW-1:0]        idx,
  input  logic signed [SW-1:0] wr_m,
  input  logic signed [SW-1:0] wr_i,
  input  logic signed [SW-1:0] wr_d,
  output logic signed [SW-1:0] rd_m,
  output logic signed [SW-1:0] rd_i,
  output logic signed [SW-1:0] rd_d
);
  // one entry per column: previous row's values until overwritten
  logic signed [SW-1:0] m_mem [MAX_LEN];
  logic signed [SW-1:0] i_mem [MAX_LEN];
  logic signed [SW-1:0] d_mem [MAX_LEN];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      m_mem[idx] <= wr_m;
      i_mem[idx] <= wr_i;
      d_mem[idx] <= wr_d;
    end
  end

  assign rd_m = m_mem[idx];
  assign rd_i = i_mem[idx];
  assign rd_d = d_mem[idx];
endmodule

// File: rtl/sw_cell_calc.sv
module sw_cell_calc #(
  parameter int SW = 21,
  parameter int PW = 8
) (
  input  logic [1:0]           base_a,
  input  logic [1:0]           base_b,
  input  logic [PW-1:0]        pen_open,
  input  logic [PW-1:0]        pen_ext,
  input  logic [PW-1:0]        bonus,
  input  logic [PW-1:0]        pen_miss,
  input  logic signed [SW-1:0] diag_m,
  input  logic signed [SW-1:0] diag_i,
  input  logic signed [SW-1:0] diag_d,
  input  logic signed [SW-1:0] up_m,
  input  logic signed [SW-1:0] up_i,
  input  logic signed [SW-1:0] left_m,
  input  logic signed [SW-1:0] left_d,
  output logic signed [SW-1:0] cell_m,
  output logic signed [SW-1:0] cell_i,
  output logic signed [SW-1:0] cell_d,
  output logic signed [SW-1:0] cell_f,
  output logic                 took_ins,
  output logic                 took_del
);
  localparam int XW = SW - PW;

  logic signed [SW-1:0] open_s, ext_s, sub_s, diag_best, m_sum;
  logic signed [SW-1:0] i_a, i_b, d_a, d_b, mi_best;

  always_comb begin
    open_s = signed'({{XW{1'b0}}, pen_open});
    ext_s  = signed'({{XW{1'b0}}, pen_ext});
    sub_s  = (base_a == base_b) ? signed'({{XW{1'b0}}, bonus})
                                : -signed'({{XW{1'b0}}, pen_miss});

    diag_best = (diag_m > diag_i) ? diag_m : diag_i;
    if (diag_d > diag_best) diag_best = diag_d;
    m_sum  = diag_best + sub_s;
    cell_m = (m_sum[SW-1]) ? '0 : m_sum;

    i_a    = up_m - open_s;
    i_b    = up_i - ext_s;
    cell_i = (i_a > i_b) ? i_a : i_b;

    d_a    = left_m - open_s;
    d_b    = left_d - ext_s;
    cell_d = (d_a > d_b) ? d_a : d_b;

    mi_best = (cell_m > cell_i) ? cell_m : cell_i;
    cell_f  = (cell_d > mi_best) ? cell_d : mi_best;

    // insertion has priority when both gap values equal the fill
    took_ins = (cell_f == cell_i);
    took_del = !took_ins && (cell_f == cell_d);
  end
endmodule

// File: rtl/sw_band_track.sv
module sw_band_track #(
  parameter int BW = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 step_en,
  input  logic                 step_dn,
  input  logic                 step_up,
  input  logic signed [BW-1:0] limit,
  output logic signed [BW-1:0] cnt_q,
  output logic                 limit_hit
);
  localparam logic signed [BW-1:0] ONE = 1;

  logic signed [BW-1:0] cnt_step, cnt_d;
  logic                 cnt_en;

  always_comb begin
    if (step_dn)      cnt_step = cnt_q - ONE;
    else if (step_up) cnt_step = cnt_q + ONE;
    else              cnt_step = cnt_q;
    limit_hit = step_en && (cnt_step == limit);
    cnt_en    = clear || step_en;
    cnt_d     = clear ? '0 : cnt_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sw_band_scorer.sv
module sw_band_scorer
  import sw_band_pkg::*;
#(
  parameter int MAX_LEN = 400,
  parameter int SW      = 21,
  parameter int PW      = 8,
  parameter int BW      = 20,
  localparam int AW     = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1,
  localparam int LW     = $clog2(MAX_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_wr_en,
  input  logic [AW-1:0]        rd_wr_addr,
  input  logic [1:0]           rd_wr_base,
  input  logic                 rf_wr_en,
  input  logic [AW-1:0]        rf_wr_addr,
  input  logic [1:0]           rf_wr_base,
  input  logic [LW-1:0]        rd_len,
  input  logic [LW-1:0]        rf_len,
  input  logic [PW-1:0]        gap_open,
  input  logic [PW-1:0]        gap_ext,
  input  logic [PW-1:0]        match_bonus,
  input  logic [PW-1:0]        mismatch_pen,
  input  logic signed [BW-1:0] band_limit,
  input  logic                 start,
  output logic                 busy,
  output logic                 done,
  output logic                 matched,
  output logic [SW-1:0]        best_score
);
  localparam logic signed [SW-1:0] NEG_VAL = {2'b11, {(SW-2){1'b0}}};
  localparam logic [LW-1:0]        IDX_ONE = 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  seq_state_e state_q, state_d;
  logic [LW-1:0] row_q, row_d, col_q, col_d, len_r_q, len_c_q;
  logic [PW-1:0] open_q, ext_q, bonus_q, miss_q;
  logic signed [BW-1:0] limit_q;
  logic signed [SW-1:0] row0_q, row0_d;
  logic signed [SW-1:0] dg_m_q, dg_i_q, dg_d_q, dg_m_d, dg_i_d, dg_d_d;
  logic signed [SW-1:0] lf_m_q, lf_d_q, lf_m_d, lf_d_d;
  logic signed [SW-1:0] best_q, best_d;
  logic matched_q, matched_d;

  logic start_ok, running, zero_len, last_col, last_cell, cfg_ld, dp_en;
  logic [LW-1:0] row_m1, col_m1;
  logic [1:0] base_rd, base_rf;
  logic signed [SW-1:0] mem_m, mem_i, mem_d, up_m, up_i, up_d;
  logic signed [SW-1:0] cell_m, cell_i, cell_d, cell_f;
  logic signed [SW-1:0] open_in, ext_ld;
  logic took_ins, took_del, band_hit;
  logic signed [BW-1:0] band_cnt;

  assign running   = (state_q == ST_RUN);
  assign start_ok  = (state_q == ST_IDLE) && start;
  assign zero_len  = (rd_len == '0) || (rf_len == '0);
  assign last_col  = (col_q == len_c_q);
  assign last_cell = last_col && (row_q == len_r_q);
  assign row_m1    = row_q - IDX_ONE;
  assign col_m1    = col_q - IDX_ONE;
  assign cfg_ld    = start_ok;
  assign dp_en     = start_ok || running;
  assign open_in   = signed'({{(SW-PW){1'b0}}, gap_open});
  assign ext_ld    = signed'({{(SW-PW){1'b0}}, ext_q});

  sw_base_store #(.MAX_LEN(MAX_LEN), .AW(AW)) u_rd_buf (
    .clk(clk), .wr_en(rd_wr_en), .wr_idx(rd_wr_addr), .wr_base(rd_wr_base),
    .rd_idx(row_m1[AW-1:0]), .rd_base(base_rd)
  );

  sw_base_store #(.MAX_LEN(MAX_LEN), .AW(AW)) u_rf_buf (
    .clk(clk), .wr_en(rf_wr_en), .wr_idx(rf_wr_addr), .wr_base(rf_wr_base),
    .rd_idx(col_m1[AW-1:0]), .rd_base(base_rf)
  );

  sw_row_store #(.MAX_LEN(MAX_LEN), .AW(AW), .SW(SW)) u_rows (
    .clk(clk), .wr_en(running), .idx(col_m1[AW-1:0]),
    .wr_m(cell_m), .wr_i(cell_i), .wr_d(cell_d),
    .rd_m(mem_m), .rd_i(mem_i), .rd_d(mem_d)
  );

  // row 1 sees the affine boundary instead of stored values
  always_comb begin
    if (row_q == IDX_ONE) begin
      up_m = row0_q; up_i = row0_q; up_d = row0_q;
    end else begin
      up_m = mem_m;  up_i = mem_i;  up_d = mem_d;
    end
  end

  sw_cell_calc #(.SW(SW), .PW(PW)) u_cell (
    .base_a(base_rd), .base_b(base_rf),
    .pen_open(open_q), .pen_ext(ext_q), .bonus(bonus_q), .pen_miss(miss_q),
    .diag_m(dg_m_q), .diag_i(dg_i_q), .diag_d(dg_d_q),
    .up_m(up_m), .up_i(up_i), .left_m(lf_m_q), .left_d(lf_d_q),
    .cell_m(cell_m), .cell_i(cell_i), .cell_d(cell_d), .cell_f(cell_f),
    .took_ins(took_ins), .took_del(took_del)
  );

  sw_band_track #(.BW(BW)) u_band (
    .clk(clk), .rst_n(rst_int_n), .clear(start_ok), .step_en(running),
    .step_dn(took_ins), .step_up(took_del), .limit(limit_q),
    .cnt_q(band_cnt), .limit_hit(band_hit)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = zero_len ? ST_FIN : ST_RUN;
      ST_RUN:  if (band_hit || last_cell) state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    row_d = row_q;   col_d = col_q;
    dg_m_d = dg_m_q; dg_i_d = dg_i_q; dg_d_d = dg_d_q;
    lf_m_d = lf_m_q; lf_d_d = lf_d_q;
    row0_d = row0_q; best_d = best_q; matched_d = matched_q;
    if (start_ok) begin
      row_d = IDX_ONE; col_d = IDX_ONE;
      dg_m_d = '0; dg_i_d = NEG_VAL; dg_d_d = NEG_VAL;
      lf_m_d = '0; lf_d_d = NEG_VAL;
      row0_d = -open_in;
      best_d = '0;
      matched_d = zero_len;
    end else if (running) begin
      if (last_col) begin
        row_d = row_q + IDX_ONE; col_d = IDX_ONE;
        dg_m_d = '0; dg_i_d = NEG_VAL; dg_d_d = NEG_VAL;
        lf_m_d = '0; lf_d_d = NEG_VAL;
      end else begin
        col_d = col_q + IDX_ONE;
        dg_m_d = up_m; dg_i_d = up_i; dg_d_d = up_d;
        lf_m_d = cell_m; lf_d_d = cell_d;
      end
      if (row_q == IDX_ONE) row0_d = row0_q - ext_ld;
      if (cell_f > best_q) best_d = cell_f;
      if (band_hit)       matched_d = 1'b0;
      else if (last_cell) matched_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q   <= ST_IDLE;
      row_q     <= '0;
      col_q     <= '0;
      len_r_q   <= '0;
      len_c_q   <= '0;
      open_q    <= '0;
      ext_q     <= '0;
      bonus_q   <= '0;
      miss_q    <= '0;
      limit_q   <= '0;
      row0_q    <= '0;
      dg_m_q    <= '0;
      dg_i_q    <= '0;
      dg_d_q    <= '0;
      lf_m_q    <= '0;
      lf_d_q    <= '0;
      best_q    <= '0;
      matched_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cfg_ld) begin
        len_r_q <= rd_len;
        len_c_q <= rf_len;
        open_q  <= gap_open;
        ext_q   <= gap_ext;
        bonus_q <= match_bonus;
        miss_q  <= mismatch_pen;
        limit_q <= band_limit;
      end
      if (dp_en) begin
        row_q     <= row_d;
        col_q     <= col_d;
        row0_q    <= row0_d;
        dg_m_q    <= dg_m_d;
        dg_i_q    <= dg_i_d;
        dg_d_q    <= dg_d_d;
        lf_m_q    <= lf_m_d;
        lf_d_q    <= lf_d_d;
        best_q    <= best_d;
        matched_q <= matched_d;
      end
    end
  end

  assign busy       = running;
  assign done       = (state_q == ST_FIN);
  assign matched    = matched_q;
  assign best_score = best_q;
endmodule

// File: rtl/sw_band_scorer_chk.sv
module sw_band_scorer_chk #(
  parameter int MAX_LEN = 400,
  parameter int SW      = 21,
  parameter int BW      = 20,
  localparam int LW     = $clog2(MAX_LEN + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic [LW-1:0]        rd_len,
  input logic [LW-1:0]        rf_len,
  input logic                 busy,
  input logic                 done,
  input logic                 matched,
  input logic [SW-1:0]        best_score,
  input logic signed [BW-1:0] band_q
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R7

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done && rd_len != '0 && rf_len != '0) |=> busy); // R7

  AST_EMPTY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done && (rd_len == '0 || rf_len == '0))
      |=> (done && matched && best_score == '0)); // R8

  AST_START_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (!busy && !done)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done && !start) |=> ($stable(matched) && $stable(best_score))); // R9

  AST_BEST_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || best_score >= $past(best_score))); // R6

  AST_BEST_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    !best_score[SW-1]); // R6

  AST_DRIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || band_q == $past(band_q)
              || band_q == BW'($past(band_q) + 1)
              || band_q == BW'($past(band_q) - 1))); // R4
endmodule

bind sw_band_scorer sw_band_scorer_chk #(
  .MAX_LEN(MAX_LEN), .SW(SW), .BW(BW)
) u_chk (
  .clk(clk), .rst_n(rst_int_n), .start(start), .rd_len(rd_len), .rf_len(rf_len),
  .busy(busy), .done(done), .matched(matched), .best_score(best_score),
  .band_q(band_cnt)
);

// File: tb/tb_sw_band_scorer.sv
module tb_sw_band_scorer;
  localparam int MAX_LEN = 400;
  localparam int SW = 21;
  localparam int PW = 8;
  localparam int BW = 20;
  localparam int AW = $clog2(MAX_LEN);
  localparam int LW = $clog2(MAX_LEN + 1);
  localparam int NEG = -(1 << 19);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_wr_en = 1'b0, rf_wr_en = 1'b0, start = 1'b0;
  logic [AW-1:0] rd_wr_addr = '0, rf_wr_addr = '0;
  logic [1:0] rd_wr_base = '0, rf_wr_base = '0;
  logic [LW-1:0] rd_len = '0, rf_len = '0;
  logic [PW-1:0] gap_open = '0, gap_ext = '0, match_bonus = '0, mismatch_pen = '0;
  logic signed [BW-1:0] band_limit = '0;
  logic busy, done, matched;
  logic [SW-1:0] best_score;

  int n_checks = 0;
  int n_err = 0;
  int rdb[MAX_LEN];
  int rfb[MAX_LEN];
  int unsigned lcg = 32'h1234_5678;

  always #10 clk = ~clk;

  sw_band_scorer dut (
    .clk(clk), .rst_n(rst_n),
    .rd_wr_en(rd_wr_en), .rd_wr_addr(rd_wr_addr), .rd_wr_base(rd_wr_base),
    .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr), .rf_wr_base(rf_wr_base),
    .rd_len(rd_len), .rf_len(rf_len), .gap_open(gap_open), .gap_ext(gap_ext),
    .match_bonus(match_bonus), .mismatch_pen(mismatch_pen),
    .band_limit(band_limit), .start(start), .busy(busy), .done(done),
    .matched(matched), .best_score(best_score)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  function automatic int rnd(input int span);
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'((lcg >> 8) % span);
  endfunction

  task automatic load_seqs(input int h, input int l);
    for (int k = 0; k < h; k++) begin
      @(negedge clk);
      rd_wr_en = 1'b1; rd_wr_addr = AW'(k); rd_wr_base = 2'(rdb[k]);
    end
    for (int k = 0; k < l; k++) begin
      @(negedge clk);
      rd_wr_en = 1'b0;
      rf_wr_en = 1'b1; rf_wr_addr = AW'(k); rf_wr_base = 2'(rfb[k]);
    end
    @(negedge clk);
    rd_wr_en = 1'b0; rf_wr_en = 1'b0;
  endtask

  // independent model of the grid walk from the requirements
  task automatic model(input int h, input int l, input int d, input int e,
                       input int ma, input int mm, input int lim,
                       output int mt, output int bs, output int cells);
    int pm[MAX_LEN+1], pin[MAX_LEN+1], pd[MAX_LEN+1];
    int dm, di, dd, lm, ld, tm, ti, td, s, cm, ci, cd, f, band, x;
    bit stop;
    mt = 1; bs = 0; cells = 0; band = 0; stop = 0;
    for (int j = 1; j <= l; j++) begin
      pm[j] = -(d + (j - 1) * e); pin[j] = pm[j]; pd[j] = pm[j];
    end
    for (int i = 1; i <= h && !stop; i++) begin
      dm = 0; di = NEG; dd = NEG; lm = 0; ld = NEG;
      for (int j = 1; j <= l && !stop; j++) begin
        tm = pm[j]; ti = pin[j]; td = pd[j];
        s = (rdb[i-1] == rfb[j-1]) ? ma : -mm;
        x = (dm > di) ? dm : di; x = (dd > x) ? dd : x;
        cm = (x + s > 0) ? x + s : 0;
        ci = (tm - d > ti - e) ? tm - d : ti - e;
        cd = (lm - d > ld - e) ? lm - d : ld - e;
        f = (cm > ci) ? cm : ci; f = (cd > f) ? cd : f;
        cells++;
        if (f == ci) band--;
        else if (f == cd) band++;
        if (f > bs) bs = f;
        dm = tm; di = ti; dd = td;
        pm[j] = cm; pin[j] = ci; pd[j] = cd; lm = cm; ld = cd;
        if (band == lim) begin mt = 0; stop = 1; end
      end
    end
  endtask

  task automatic run_job(input int h, input int l, input int d, input int e,
                         input int ma, input int mm, input int lim,
                         output int lat, output int gm, output int gb);
    @(negedge clk);
    rd_len = LW'(h); rf_len = LW'(l);
    gap_open = PW'(d); gap_ext = PW'(e); match_bonus = PW'(ma); mismatch_pen = PW'(mm);
    band_limit = BW'(lim); start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 1;
    while (!done && lat < 5000) begin @(negedge clk); lat++; end
    gm = int'(matched); gb = int'(best_score);
  endtask

  task automatic job_vs_model(input string tag, input int h, input int l,
                              input int d, input int e, input int ma,
                              input int mm, input int lim);
    int lat, gm, gb, em, eb, ec;
    model(h, l, d, e, ma, mm, lim, em, eb, ec);
    load_seqs(h, l);
    run_job(h, l, d, e, ma, mm, lim, lat, gm, gb);
    chk({tag, " matched"}, gm, em);
    chk({tag, " score"}, gb, eb);
    chk({tag, " latency R7"}, lat, ec + 1);
  endtask

  task automatic t_reset;
    chk("R10 busy", int'(busy), 0);
    chk("R10 done", int'(done), 0);
    chk("R10 matched", int'(matched), 0);
    chk("R10 score", int'(best_score), 0);
  endtask

  task automatic t_identity; // R1 R2 R6: equal 4-base strings
    int lat, gm, gb;
    rdb[0] = 0; rdb[1] = 1; rdb[2] = 2; rdb[3] = 3;
    rfb[0] = 0; rfb[1] = 1; rfb[2] = 2; rfb[3] = 3;
    load_seqs(4, 4);
    run_job(4, 4, 2, 1, 5, 3, 1000, lat, gm, gb);
    chk("R6 identity matched", gm, 1);
    chk("R2 identity score", gb, 20);
    chk("R7 identity latency", lat, 17);
    job_vs_model("R1 identity model", 4, 4, 2, 1, 5, 3, 1000);
  endtask

  task automatic t_del_stop; // R4 R5: deletion drives counter to +1
    int lat, gm, gb;
    rdb[0] = 0; rfb[0] = 0; rfb[1] = 1; rfb[2] = 2;
    load_seqs(1, 3);
    run_job(1, 3, 2, 1, 5, 3, 1, lat, gm, gb);
    chk("R5 del stop matched", gm, 0);
    chk("R5 del stop score", gb, 5);
    chk("R4 del stop latency", lat, 3);
  endtask

  task automatic t_ins_stop; // R4 R5: insertion drives counter to -1
    int lat, gm, gb;
    rdb[0] = 0; rdb[1] = 1; rdb[2] = 3; rfb[0] = 0;
    load_seqs(3, 1);
    run_job(3, 1, 2, 1, 5, 3, -1, lat, gm, gb);
    chk("R5 ins stop matched", gm, 0);
    chk("R5 ins stop score", gb, 5);
    chk("R4 ins stop latency", lat, 3);
  endtask

  task automatic t_boundary; // R3: row-0 affine values reduce the diagonal
    int lat, gm, gb;
    rdb[0] = 0; rfb[0] = 1; rfb[1] = 1; rfb[2] = 0;
    load_seqs(1, 3);
    run_job(1, 3, 2, 1, 5, 3, 100, lat, gm, gb);
    chk("R3 boundary score", gb, 2);
    chk("R3 boundary matched", gm, 1);
    chk("R3 boundary latency", lat, 4);
  endtask

  task automatic t_zero_len; // R8
    int lat, gm, gb;
    run_job(0, 7, 2, 1, 5, 3, 1, lat, gm, gb);
    chk("R8 empty latency", lat, 1);
    chk("R8 empty matched", gm, 1);
    chk("R8 empty score", gb, 0);
    run_job(5, 0, 2, 1, 5, 3, 1, lat, gm, gb);
    chk("R8 empty ref latency", lat, 1);
  endtask

  task automatic t_busy_start; // R9: second start during a run is dropped
    int lat, em, eb, ec;
    for (int k = 0; k < 6; k++) begin rdb[k] = rnd(4); rfb[k] = rnd(4); end
    model(6, 6, 3, 1, 4, 2, 1000, em, eb, ec);
    load_seqs(6, 6);
    @(negedge clk);
    rd_len = LW'(6); rf_len = LW'(6); gap_open = 8'd3; gap_ext = 8'd1;
    match_bonus = 8'd4; mismatch_pen = 8'd2; band_limit = BW'(1000); start = 1'b1;
    @(negedge clk); start = 1'b0; lat = 1;
    @(negedge clk); lat++;
    rd_len = LW'(2); rf_len = LW'(0); band_limit = BW'(1); start = 1'b1;
    @(negedge clk); lat++; start = 1'b0;
    while (!done && lat < 5000) begin @(negedge clk); lat++; end
    chk("R9 restart ignored latency", lat, ec + 1);
    chk("R9 restart ignored matched", int'(matched), em);
    chk("R9 restart ignored score", int'(best_score), eb);
    start = 1'b1; rd_len = LW'(0);
    @(negedge clk); start = 1'b0;
    chk("R9 start in done ignored", int'(busy || done), 0);
    repeat (4) @(negedge clk);
    chk("R9 hold matched", int'(matched), em);
    chk("R9 hold score", int'(best_score), eb);
    chk("R7 done one cycle", int'(done), 0);
  endtask

  task automatic t_random; // R2 R3 R4 R5 R6 against the model
    int lims[6] = '{1, 2, -1, -2, 3, 1000};
    for (int n = 0; n < 10; n++) begin
      int h = 3 + rnd(20);
      int l = 3 + rnd(20);
      for (int k = 0; k < h; k++) rdb[k] = rnd(4);
      for (int k = 0; k < l; k++) rfb[k] = (rnd(3) == 0) ? rnd(4) : rdb[k % h];
      job_vs_model($sformatf("R4 random %0d", n), h, l, 1 + rnd(4), 1 + rnd(2),
                   2 + rnd(5), 1 + rnd(4), lims[n % 6]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_identity();
    t_del_stop();
    t_ins_stop();
    t_boundary();
    t_zero_len();
    t_busy_start();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule